// File: doc/BRIEF.md
# Read-Only Host Port to ISA I/O Bridge

This block lets a host that can only issue read cycles on a cartridge-style port drive a small 8-bit ISA-style I/O bus. Two address windows are decoded. A host read in the lower window turns into an ISA read strobe, and the byte the peripheral returns comes back on the upper host data lanes. A host read in the upper window, one address bit higher, turns into an ISA write strobe. The byte written is not taken from the data bus. It comes from host address lines A1 to A8, which the bridge registers and drives onto the ISA data lines.

Host address lines A9 to A13 select one of 32 ISA registers. The remaining ISA address bits are fixed so that the decoded I/O base is 0x300. A mode input adds two word-wide variants for a 16-bit peripheral. In word-read mode the whole 16-bit input word is returned in one access. In word-write mode a lower-window access only stores a low byte. The following upper-window access then writes the stored low byte together with the new high byte as one word, and the stored byte is released when that write ends. Every strobe lasts a fixed, parameter-set number of clock cycles. While a strobe is active the bridge reports busy and ignores new requests.

Top module: `rdonly_isa_bridge`

## Requirements
- R1: After a synchronous active-high reset the following outputs are all low: isa_ior, isa_iow, busy, lo_pend, host_rd_done and host_dout. isa_addr equals 0x300.
- R2: On an accepted access, isa_addr equals 0x300 OR host_addr[13:9], and it stays stable while the strobe is active.
- R3: In mode 2'b00, a lower-window access (host_addr[16]=0) raises isa_ior and busy from the cycle after the request for exactly STROBE_CYC cycles. In the cycle after the strobe ends, host_rd_done pulses for one cycle and host_dout holds {isa_din[7:0], 8'h00}, captured in the last strobe cycle.
- R4: In mode 2'b01, a lower-window access behaves as in R3, but host_dout holds the full isa_din[15:0].
- R5: In mode 2'b00 or 2'b01, an upper-window access (host_addr[16]=1) raises isa_iow for STROBE_CYC cycles, with isa_dout = {8'h00, host_addr[8:1]}. It gives no host_rd_done, and a pending low byte stays pending.
- R6: In mode 2'b10, a lower-window access produces no strobe and no busy. It stores host_addr[8:1] as the low byte and sets lo_pend from the next cycle, and host_dout is unchanged.
- R7: In mode 2'b10, an upper-window access raises isa_iow for STROBE_CYC cycles with isa_dout = {host_addr[8:1], stored low byte}, using 8'h00 when no byte is stored. lo_pend is low in the cycle after the strobe ends.
- R8: A request is ignored while busy is high, while host_cs is low, or while host_addr[15:14] is nonzero. An ignored request starts no strobe and leaves isa_addr and lo_pend unchanged.
- R9: isa_ior and isa_iow are never high in the same cycle.
- R10: A reset during a strobe drops the strobe, busy and lo_pend in the next cycle, and gives no host_rd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle pulse marking a host read access |
| host_cs | input | 1 | Host port select for the bridge |
| host_addr | input | 16 (HA_W-1:1) | Host address lines A1..A16 |
| host_mode | input | 2 | 00 byte, 01 word read, 10 word write, 11 byte |
| host_dout | output | 16 | Data returned to the host, ISA byte on the upper lanes |
| host_rd_done | output | 1 | One-cycle pulse when host_dout has been updated |
| busy | output | 1 | High while an ISA strobe is active |
| lo_pend | output | 1 | A stored low byte waits for a word write |
| isa_addr | output | 10 | ISA I/O address |
| isa_dout | output | 16 | Write data toward the peripheral |
| isa_din | input | 16 | Read data from the peripheral |
| isa_ior | output | 1 | ISA read strobe, active high |
| isa_iow | output | 1 | ISA write strobe, active high |

## Verification
A wrong strobe counter shows as an isa_ior or isa_iow pulse whose length differs from STROBE_CYC, and the busy-window test shows it within a few cycles of the request. A corrupted window or mode decode shows in the first strobe cycle, either as the wrong strobe or as no strobe where one is expected. A mis-sliced address or data field shows in isa_addr, isa_dout or host_dout in that same cycle. Faults in the low-byte store take longer to appear. They surface only at the next word write, as a wrong upper or lower byte in isa_dout or as lo_pend staying high after that write.

// File: rtl/rpib_pkg.sv
`timescale 1ns/1ps
package rpib_pkg;
    typedef enum logic [1:0] {
        MODE_BYTE = 2'b00,
        MODE_WRD  = 2'b01,
        MODE_WWR  = 2'b10,
        MODE_RSV  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_RD_B  = 3'd1,
        OP_RD_W  = 3'd2,
        OP_LATCH = 3'd3,
        OP_WR_B  = 3'd4,
        OP_WR_W  = 3'd5
    } op_e;
endpackage

// File: rtl/rpib_decode.sv
`timescale 1ns/1ps
module rpib_decode
    import rpib_pkg::*;
#(
    parameter int unsigned HA_W    = 17,
    parameter int unsigned WIN_BIT = 16,
    parameter int unsigned IDX_LSB = 9,
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned DAT_LSB = 1,
    parameter int unsigned BYTE_W  = 8
) (
    input  logic              req,
    input  logic              cs,
    input  logic              busy,
    input  logic [HA_W-1:1]   addr,
    input  logic [1:0]        mode,
    output op_e               op,
    output logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] payload
);
    localparam int unsigned GAP_LSB = IDX_LSB + IDX_W;

    logic hit;

    always_comb begin
        idx     = addr[IDX_LSB +: IDX_W];
        payload = addr[DAT_LSB +: BYTE_W];
        hit     = req && cs && !busy && (addr[WIN_BIT-1:GAP_LSB] == '0);
        op      = OP_NONE;
        if (hit) begin
            if (addr[WIN_BIT]) begin
                op = (mode == MODE_WWR) ? OP_WR_W : OP_WR_B;
            end else begin
                case (mode)
                    MODE_WRD: op = OP_RD_W;
                    MODE_WWR: op = OP_LATCH;
                    default:  op = OP_RD_B;
                endcase
            end
        end
    end
endmodule

// File: rtl/rpib_timer.sv
`timescale 1ns/1ps
module rpib_timer #(
    parameter int unsigned STROBE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int unsigned CW = $clog2(STROBE_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(STROBE_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == CW'(1));
endmodule

// File: rtl/rpib_lolatch.sv
`timescale 1ns/1ps
module rpib_lolatch #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] lo,
    output logic              pend
);
    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] lo;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (clr) begin
            lat_d = '0;
        end else if (set) begin
            lat_d.pend = 1'b1;
            lat_d.lo   = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end

    assign lo   = lat_q.lo;
    assign pend = lat_q.pend;
endmodule

// File: rtl/rdonly_isa_bridge.sv
`timescale 1ns/1ps
module rdonly_isa_bridge
    import rpib_pkg::*;
#(
    parameter int unsigned HA_W       = 17,
    parameter int unsigned WIN_BIT    = 16,
    parameter int unsigned IDX_LSB    = 9,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned DAT_LSB    = 1,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ISA_AW     = 10,
    parameter logic [9:0]  ISA_BASE   = 10'h300,
    parameter int unsigned STROBE_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_req,
    input  logic                  host_cs,
    input  logic [HA_W-1:1]       host_addr,
    input  logic [1:0]            host_mode,
    output logic [2*BYTE_W-1:0]   host_dout,
    output logic                  host_rd_done,
    output logic                  busy,
    output logic                  lo_pend,
    output logic [ISA_AW-1:0]     isa_addr,
    output logic [2*BYTE_W-1:0]   isa_dout,
    input  logic [2*BYTE_W-1:0]   isa_din,
    output logic                  isa_ior,
    output logic                  isa_iow
);
    localparam int unsigned HD_W = 2 * BYTE_W;

    typedef struct packed {
        logic              ior;
        logic              iow;
        logic              wide_rd;
        logic              wide_wr;
        logic [ISA_AW-1:0] addr;
        logic [HD_W-1:0]   dout;
        logic [HD_W-1:0]   hdout;
        logic              rd_done;
    } st_t;

    st_t st_d, st_q;

    op_e               op;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] payload;
    logic [BYTE_W-1:0] lo_byte;
    logic              tmr_active;
    logic              tmr_last;
    logic              start;
    logic              lat_set;
    logic              lat_clr;

    rpib_decode #(
        .HA_W(HA_W), .WIN_BIT(WIN_BIT), .IDX_LSB(IDX_LSB),
        .IDX_W(IDX_W), .DAT_LSB(DAT_LSB), .BYTE_W(BYTE_W)
    ) u_dec (
        .req(host_req), .cs(host_cs), .busy(tmr_active),
        .addr(host_addr), .mode(host_mode),
        .op(op), .idx(idx), .payload(payload)
    );

    assign start   = (op != OP_NONE) && (op != OP_LATCH);
    assign lat_set = (op == OP_LATCH);
    assign lat_clr = tmr_last && st_q.wide_wr;

    rpib_timer #(.STROBE_CYC(STROBE_CYC)) u_tmr (
        .clk(clk), .rst(rst), .start(start),
        .active(tmr_active), .last(tmr_last)
    );

    rpib_lolatch #(.BYTE_W(BYTE_W)) u_lat (
        .clk(clk), .rst(rst), .set(lat_set), .clr(lat_clr),
        .din(payload), .lo(lo_byte), .pend(lo_pend)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rd_done = 1'b0;
        if (start) begin
            st_d.ior     = (op == OP_RD_B) || (op == OP_RD_W);
            st_d.iow     = (op == OP_WR_B) || (op == OP_WR_W);
            st_d.wide_rd = (op == OP_RD_W);
            st_d.wide_wr = (op == OP_WR_W);
            st_d.addr    = ISA_BASE | ISA_AW'(idx);
            if (op == OP_WR_W) begin
                st_d.dout = {payload, lo_byte};
            end else if (op == OP_WR_B) begin
                st_d.dout = {{BYTE_W{1'b0}}, payload};
            end
        end else if (tmr_last) begin
            if (st_q.ior) begin
                st_d.hdout   = st_q.wide_rd ? isa_din
                                            : {isa_din[BYTE_W-1:0], {BYTE_W{1'b0}}};
                st_d.rd_done = 1'b1;
            end
            st_d.ior     = 1'b0;
            st_d.iow     = 1'b0;
            st_d.wide_rd = 1'b0;
            st_d.wide_wr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.addr <= ISA_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_dout    = st_q.hdout;
    assign host_rd_done = st_q.rd_done;
    assign busy         = tmr_active;
    assign isa_addr     = st_q.addr;
    assign isa_dout     = st_q.dout;
    assign isa_ior      = st_q.ior;
    assign isa_iow      = st_q.iow;
endmodule

// File: rtl/rdonly_isa_bridge_chk.sv
`timescale 1ns/1ps
module rdonly_isa_bridge_chk #(
    parameter int unsigned ISA_AW     = 10,
    parameter int unsigned HD_W       = 16,
    parameter int unsigned STROBE_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              isa_ior,
    input logic              isa_iow,
    input logic              busy,
    input logic              lo_pend,
    input logic              host_rd_done,
    input logic [ISA_AW-1:0] isa_addr,
    input logic [HD_W-1:0]   isa_dout
);
    logic       str;
    logic [7:0] run_q;

    assign str = isa_ior || isa_iow;

    always_ff @(posedge clk) begin
        if (rst)                run_q <= '0;
        else if (!str)          run_q <= '0;
        else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
    end

    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(isa_ior && isa_iow));

    a_r3_strobe_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(str) && !$past(rst)) |-> (run_q == 8'(STROBE_CYC)));

    a_r3_busy_match: assert property (@(posedge clk) disable iff (rst)
        busy == str);

    a_r2_hold_fields: assert property (@(posedge clk) disable iff (rst)
        (str && $past(str)) |-> ($stable(isa_addr) && $stable(isa_dout)));

    a_r7_pend_clear: assert property (@(posedge clk) disable iff (rst)
        ($fell(lo_pend) && !$past(rst)) |-> $past(isa_iow));

    a_r3_done_after_ior: assert property (@(posedge clk) disable iff (rst)
        host_rd_done |-> ($past(isa_ior) && !isa_ior));

    a_r6_latch_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_pend) |-> !str);
endmodule

bind rdonly_isa_bridge rdonly_isa_bridge_chk #(
    .ISA_AW(ISA_AW), .HD_W(2*BYTE_W), .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk(clk), .rst(rst), .isa_ior(isa_ior), .isa_iow(isa_iow),
    .busy(busy), .lo_pend(lo_pend), .host_rd_done(host_rd_done),
    .isa_addr(isa_addr), .isa_dout(isa_dout)
);

// File: tb/rdonly_isa_bridge_tb.sv
`timescale 1ns/1ps
module rdonly_isa_bridge_tb;
    localparam int S = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_cs = 1'b0;
    logic [16:1] host_addr = '0;
    logic [1:0]  host_mode = 2'b00;
    logic [15:0] host_dout;
    logic        host_rd_done;
    logic        busy;
    logic        lo_pend;
    logic [9:0]  isa_addr;
    logic [15:0] isa_dout;
    logic [15:0] isa_din = '0;
    logic        isa_ior;
    logic        isa_iow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    rdonly_isa_bridge #(.STROBE_CYC(S)) u_dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_cs(host_cs),
        .host_addr(host_addr), .host_mode(host_mode), .host_dout(host_dout),
        .host_rd_done(host_rd_done), .busy(busy), .lo_pend(lo_pend),
        .isa_addr(isa_addr), .isa_dout(isa_dout), .isa_din(isa_din),
        .isa_ior(isa_ior), .isa_iow(isa_iow)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:1] mk(input logic win, input logic [1:0] gap,
                                       input logic [4:0] idx, input logic [7:0] b);
        return {win, gap, idx, b};
    endfunction

    // Scoreboard monitor: compares host data whenever a read completes.
    always @(negedge clk) begin
        if (!rst && host_rd_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected host_rd_done", 32'(host_dout), 32'hFFFF);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(host_dout == e, "R3/R4 host_dout", 32'(host_dout), 32'(e));
            end
        end
    end

    task automatic issue(input logic cs, input logic [16:1] a, input logic [1:0] m);
        @(negedge clk);
        host_req = 1'b1; host_cs = cs; host_addr = a; host_mode = m;
        @(negedge clk);
        host_req = 1'b0; host_cs = 1'b0;
    endtask

    task automatic count_strobe(output int n);
        n = 0;
        while ((isa_ior || isa_iow) && n < 100) begin
            if (isa_ior && isa_iow) chk(1'b0, "R9 both strobes", 32'd3, 32'd1);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_all();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_all();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!isa_ior && !isa_iow && !busy, "R1 strobes/busy", {isa_ior, isa_iow, busy}, 0);
        chk(!lo_pend && !host_rd_done && host_dout == 0, "R1 latch/data",
            {lo_pend, host_rd_done, host_dout}, 0);
        chk(isa_addr == 10'h300, "R1 isa_addr", 32'(isa_addr), 32'h300);

        // R3 byte read
        isa_din = 16'hA55A;
        exp_q.push_back(16'h5A00);
        issue(1'b1, mk(1'b0, 2'b00, 5'h0A, 8'hFF), 2'b00);
        chk(isa_ior && !isa_iow && busy, "R3 ior+busy", {isa_ior, isa_iow, busy}, 3'b101);
        chk(isa_addr == 10'h30A, "R2 isa_addr", 32'(isa_addr), 32'h30A);
        count_strobe(n);
        chk(n == S, "R3 strobe length", n, S);
        @(negedge clk);
        chk(!host_rd_done, "R3 done one cycle", 32'(host_rd_done), 0);

        // R4 word read
        isa_din = 16'hBEEF;
        exp_q.push_back(16'hBEEF);
        issue(1'b1, mk(1'b0, 2'b00, 5'h1F, 8'h00), 2'b01);
        chk(isa_addr == 10'h31F, "R2 isa_addr top idx", 32'(isa_addr), 32'h31F);
        count_strobe(n);
        chk(n == S, "R4 strobe length", n, S);

        // R5 byte write
        issue(1'b1, mk(1'b1, 2'b00, 5'h03, 8'hC3), 2'b00);
        chk(isa_iow && !isa_ior, "R5 iow", {isa_ior, isa_iow}, 2'b01);
        chk(isa_dout == 16'h00C3, "R5 isa_dout", 32'(isa_dout), 32'h00C3);
        chk(isa_addr == 10'h303, "R2 write addr", 32'(isa_addr), 32'h303);
        count_strobe(n);
        chk(n == S, "R5 strobe length", n, S);

        // R6 latch low byte
        issue(1'b1, mk(1'b0, 2'b00, 5'h00, 8'h34), 2'b10);
        chk(!isa_ior && !isa_iow && !busy, "R6 no strobe", {isa_ior, isa_iow, busy}, 0);
        chk(lo_pend, "R6 lo_pend set", 32'(lo_pend), 1);
        chk(host_dout == 16'hBEEF, "R6 host_dout kept", 32'(host_dout), 32'hBEEF);

        // R7 word write
        issue(1'b1, mk(1'b1, 2'b00, 5'h07, 8'h12), 2'b10);
        chk(isa_iow && isa_dout == 16'h1234, "R7 word dout", 32'(isa_dout), 32'h1234);
        count_strobe(n);
        chk(n == S, "R7 strobe length", n, S);
        chk(!lo_pend, "R7 lo_pend cleared", 32'(lo_pend), 0);

        // R8 ignored requests
        issue(1'b0, mk(1'b0, 2'b00, 5'h01, 8'h00), 2'b00);
        chk(!isa_ior && !busy && isa_addr == 10'h307, "R8 cs low ignored",
            {isa_ior, busy, isa_addr}, 32'h307);
        issue(1'b1, mk(1'b0, 2'b01, 5'h01, 8'h00), 2'b00);
        chk(!isa_ior && !busy && isa_addr == 10'h307, "R8 gap bits ignored",
            {isa_ior, busy, isa_addr}, 32'h307);
        issue(1'b1, mk(1'b0, 2'b10, 5'h01, 8'h56), 2'b10);
        chk(!lo_pend, "R8 latch outside window ignored", 32'(lo_pend), 0);

        // R8 request while busy
        isa_din = 16'h0011;
        exp_q.push_back(16'h1100);
        issue(1'b1, mk(1'b0, 2'b00, 5'h02, 8'h00), 2'b00);
        issue(1'b1, mk(1'b1, 2'b00, 5'h09, 8'h99), 2'b00);
        chk(isa_ior && !isa_iow && isa_addr == 10'h302, "R8 busy ignored",
            {isa_ior, isa_iow, isa_addr}, {2'b10, 10'h302});
        count_strobe(n);
        chk(n == S - 2, "R8 strobe not restarted", n, S - 2);

        // R5 byte write keeps a pending latch, R7 then uses it
        issue(1'b1, mk(1'b0, 2'b00, 5'h00, 8'h77), 2'b10);
        issue(1'b1, mk(1'b1, 2'b00, 5'h04, 8'h55), 2'b00);
        chk(isa_dout == 16'h0055, "R5 byte dout with latch", 32'(isa_dout), 32'h0055);
        count_strobe(n);
        chk(lo_pend, "R5 latch kept", 32'(lo_pend), 1);
        issue(1'b1, mk(1'b1, 2'b00, 5'h04, 8'hAA), 2'b10);
        chk(isa_dout == 16'hAA77, "R7 stored low byte", 32'(isa_dout), 32'hAA77);
        count_strobe(n);
        chk(!lo_pend, "R7 cleared after write", 32'(lo_pend), 0);

        // R7 word write without stored byte
        issue(1'b1, mk(1'b1, 2'b00, 5'h05, 8'h3C), 2'b10);
        chk(isa_dout == 16'h3C00, "R7 no stored byte", 32'(isa_dout), 32'h3C00);
        count_strobe(n);

        // R10 reset during a strobe
        issue(1'b1, mk(1'b0, 2'b00, 5'h00, 8'h21), 2'b10);
        isa_din = 16'hFFFF;
        issue(1'b1, mk(1'b0, 2'b00, 5'h06, 8'h00), 2'b00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!isa_ior && !busy && !lo_pend, "R10 reset mid strobe",
            {isa_ior, busy, lo_pend}, 0);
        chk(isa_addr == 10'h300 && !host_rd_done, "R10 addr/done",
            {host_rd_done, isa_addr}, 32'h300);
        repeat (S + 2) @(negedge clk);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        finish_all();
    end
endmodule